// File: doc/BRIEF.md
# Region-of-Interest Coded Block Selector

This block decides, block by block, whether each 8x8 block of a video frame is coded. Host software first fills two bit maps held on chip. Each map has one entry per 32x32-pixel tile. The first map marks the tiles whose blocks are coded. The second map picks, for each tile, which of two quantiser index values the encoder uses. The block does not analyse the image: it only looks up what software has loaded.

Each frame starts with a pulse that carries the frame type and a quantiser-map enable. There are three frame types:

- An intra frame codes every block.
- A full inter frame also codes every block.
- A map-driven inter frame codes a block only when the map bit of its tile is set.

The block column and row are presented on a scan interface. The coded flag and the quantiser select come back registered, one cycle later. The map cannot be written while a frame is being scanned, so every block of a frame sees the same map.

Top module: `roi_block_selector`

## Requirements
- R1: After reset, `res_valid` is 0, `host_ready` is 1, and every entry of both maps is 0.
- R2: In a frame started with `frame_type` = 0 (intra), every looked-up block reports `res_coded` = 1, whatever the map holds.
- R3: In a frame started with `frame_type` = 1 (full inter), every looked-up block reports `res_coded` = 1, whatever the map holds.
- R4: In a frame started with `frame_type` = 2 (map inter), `res_coded` equals the coded-map bit of tile (`blk_col`>>2, `blk_row`>>2).
- R5: `frame_type` = 3 is treated as full inter: every block is coded.
- R6: `res_qsel` equals the quantiser-map bit of the block's tile when `frame_qmap_en` was 1 at frame start, and is 0 otherwise. This holds in every frame type.
- R7: A lookup accepted on a clock edge while a frame is open sets `res_valid` = 1 for exactly the following cycle. The result fields belong to that lookup.
- R8: `host_ready` goes low in the cycle after `frame_start` and returns high in the cycle after a `frame_end` that has no `frame_start` with it. A `host_we` presented while `host_ready` is 0 leaves both maps unchanged.
- R9: A `blk_valid` presented while no frame is open is ignored, and `res_valid` stays 0.
- R10: `frame_type` and `frame_qmap_en` are sampled only with `frame_start`. Changing them in the middle of a frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Map write strobe |
| host_tile_col | input | TILE_COL_W | Tile column being written |
| host_tile_row | input | TILE_ROW_W | Tile row being written |
| host_code_bit | input | 1 | Coded-map value to write |
| host_q_bit | input | 1 | Quantiser-map value to write |
| host_ready | output | 1 | High when no frame is open and writes take effect |
| frame_start | input | 1 | Opens a frame and samples the type and enable |
| frame_end | input | 1 | Closes the open frame |
| frame_type | input | 2 | 0 intra, 1 full inter, 2 map inter, 3 full inter |
| frame_qmap_en | input | 1 | Enables the quantiser map for the frame |
| blk_valid | input | 1 | Block lookup strobe |
| blk_col | input | TILE_COL_W+2 | Block column in 8x8 units |
| blk_row | input | TILE_ROW_W+2 | Block row in 8x8 units |
| res_valid | output | 1 | Result valid, one cycle after the lookup |
| res_coded | output | 1 | Block is coded |
| res_qsel | output | 1 | Selects the second quantiser index |

## Verification
A corrupted map entry shows only in a map-driven frame, and only on `res_coded` for blocks of that tile. It appears one cycle after such a block is looked up. A stale frame type shows on the first lookup of the frame as a coded flag that ignores, or wrongly applies, the map. A frame-open flag stuck in the wrong state shows at once on `host_ready`, and on the next lookup as a missing or spurious `res_valid`. The vectors therefore revisit the same tiles under every frame type.

// File: rtl/roi_block_selector.sv
module roi_block_selector #(
  parameter int TILE_COL_W = 5,
  parameter int TILE_ROW_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic [TILE_COL_W-1:0] host_tile_col,
  input  logic [TILE_ROW_W-1:0] host_tile_row,
  input  logic                  host_code_bit,
  input  logic                  host_q_bit,
  output logic                  host_ready,
  input  logic                  frame_start,
  input  logic                  frame_end,
  input  logic [1:0]            frame_type,
  input  logic                  frame_qmap_en,
  input  logic                  blk_valid,
  input  logic [TILE_COL_W+1:0] blk_col,
  input  logic [TILE_ROW_W+1:0] blk_row,
  output logic                  res_valid,
  output logic                  res_coded,
  output logic                  res_qsel
);
  localparam int TILES = 1 << (TILE_COL_W + TILE_ROW_W);
  localparam int IDX_W = TILE_COL_W + TILE_ROW_W;
  localparam logic [1:0] FT_MAP = 2'd2;

  logic [TILES-1:0] code_map, q_map;
  logic             in_frame, cur_qen;
  logic [1:0]       cur_type;

  wire [IDX_W-1:0] wr_idx = {host_tile_row, host_tile_col};
  wire [IDX_W-1:0] rd_idx = {blk_row[TILE_ROW_W+1:2], blk_col[TILE_COL_W+1:2]};
  wire             wr_ok  = host_we && !in_frame;
  wire             lookup = blk_valid && in_frame;

  assign host_ready = !in_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      cur_type <= 2'd0;
      cur_qen  <= 1'b0;
    end else if (frame_start) begin
      in_frame <= 1'b1;
      cur_type <= frame_type;
      cur_qen  <= frame_qmap_en;
    end else if (frame_end) begin
      in_frame <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_map <= '0;
      q_map    <= '0;
    end else if (wr_ok) begin
      code_map[wr_idx] <= host_code_bit;
      q_map[wr_idx]    <= host_q_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_coded <= 1'b0;
      res_qsel  <= 1'b0;
    end else begin
      res_valid <= lookup;
      if (lookup) begin
        res_coded <= (cur_type == FT_MAP) ? code_map[rd_idx] : 1'b1;
        res_qsel  <= cur_qen & q_map[rd_idx];
      end
    end
  end
endmodule

// File: rtl/roi_block_selector_chk.sv
module roi_block_selector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_ready,
  input logic       frame_start,
  input logic       frame_end,
  input logic       blk_valid,
  input logic       res_valid,
  input logic       res_coded,
  input logic       res_qsel,
  input logic [1:0] cur_type,
  input logic       cur_qen
);
  a_r7_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !host_ready) |=> res_valid);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_valid |=> !res_valid);
  a_r9_closed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && host_ready) |=> !res_valid);
  a_r8_open_blocks_host: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !host_ready);
  a_r8_close_frees_host: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_start) |=> host_ready);
  a_r2_full_types_coded: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cur_type != 2'd2) |-> res_coded);
  a_r6_qmap_off: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !cur_qen) |-> !res_qsel);
endmodule

bind roi_block_selector roi_block_selector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready),
  .frame_start(frame_start), .frame_end(frame_end), .blk_valid(blk_valid),
  .res_valid(res_valid), .res_coded(res_coded), .res_qsel(res_qsel),
  .cur_type(cur_type), .cur_qen(cur_qen)
);

// File: tb/test_roi_block_selector.sv
module test_roi_block_selector;
  logic clk = 0, rst_n = 0;
  logic host_we = 0, host_code_bit = 0, host_q_bit = 0;
  logic [4:0] host_tile_col = 0;
  logic [3:0] host_tile_row = 0;
  logic frame_start = 0, frame_end = 0, frame_qmap_en = 0, blk_valid = 0;
  logic [1:0] frame_type = 0;
  logic [6:0] blk_col = 0;
  logic [5:0] blk_row = 0;
  logic host_ready, res_valid, res_coded, res_qsel;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  roi_block_selector i_roi_block_selector (.*);

  // entry: type(2) qen(1) col(7) row(6) exp_coded(1) exp_q(1)
  localparam logic [17:0] VEC [12] = '{
    {2'd2, 1'b1, 7'd12,  6'd8,  1'b1, 1'b1},
    {2'd2, 1'b1, 7'd15,  6'd11, 1'b1, 1'b1},
    {2'd2, 1'b1, 7'd16,  6'd8,  1'b0, 1'b0},
    {2'd2, 1'b0, 7'd13,  6'd9,  1'b1, 1'b0},
    {2'd0, 1'b1, 7'd20,  6'd4,  1'b1, 1'b0},
    {2'd0, 1'b1, 7'd127, 6'd63, 1'b1, 1'b1},
    {2'd2, 1'b1, 7'd127, 6'd63, 1'b0, 1'b1},
    {2'd1, 1'b1, 7'd0,   6'd0,  1'b1, 1'b0},
    {2'd2, 1'b1, 7'd2,   6'd1,  1'b1, 1'b0},
    {2'd3, 1'b0, 7'd64,  6'd40, 1'b1, 1'b0},
    {2'd2, 1'b1, 7'd22,  6'd29, 1'b1, 1'b1},
    {2'd1, 1'b0, 7'd22,  6'd29, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input int c, input int r, input logic cb, input logic qb);
    @(negedge clk);
    host_we = 1; host_tile_col = 5'(c); host_tile_row = 4'(r);
    host_code_bit = cb; host_q_bit = qb;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic open_frame(input logic [1:0] t, input logic q);
    @(negedge clk);
    frame_start = 1; frame_type = t; frame_qmap_en = q;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic close_frame;
    @(negedge clk);
    frame_end = 1;
    @(negedge clk);
    frame_end = 0;
  endtask

  task automatic look(input int c, input int r);
    @(negedge clk);
    blk_valid = 1; blk_col = 7'(c); blk_row = 6'(r);
    @(negedge clk);
    blk_valid = 0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {res_valid, host_ready, 1'b0}, 3'b010);
    rst_n = 1;
    // R1: map clear after reset
    open_frame(2'd2, 1'b1);
    look(12, 8);
    check("R1 map cleared", {res_valid, res_coded, res_qsel}, 3'b100);
    close_frame();

    wr(3, 2, 1, 1);
    wr(0, 0, 1, 0);
    wr(31, 15, 0, 1);
    wr(5, 7, 1, 1);

    // R2 R3 R4 R5 R6: vector table
    for (int i = 0; i < 12; i++) begin
      open_frame(VEC[i][17:16], VEC[i][15]);
      look(int'(VEC[i][14:8]), int'(VEC[i][7:2]));
      check($sformatf("R4/R2/R3/R5/R6 vec %0d", i),
            {res_valid, res_coded, res_qsel}, {1'b1, VEC[i][1:0]});
      close_frame();
    end

    // R7: valid lasts one cycle
    open_frame(2'd2, 1'b1);
    look(12, 8);
    @(negedge clk);
    check("R7 valid single cycle", {res_valid, 2'b00}, 3'b000);
    // R8: host blocked while frame open, write ignored
    check("R8 host_ready low", {host_ready, 2'b00}, 3'b000);
    wr(10, 10, 1, 1);
    // R10: type change mid-frame has no effect
    frame_type = 2'd0; frame_qmap_en = 0;
    look(40, 40);
    check("R10 mid-frame type change", {res_valid, res_coded, res_qsel}, 3'b100);
    close_frame();
    check("R8 host_ready back", {host_ready, 2'b00}, 3'b100);
    open_frame(2'd2, 1'b1);
    look(40, 40);
    check("R8 write during frame ignored", {res_valid, res_coded, res_qsel}, 3'b100);
    close_frame();

    // R9: lookup with no frame open
    look(12, 8);
    check("R9 closed lookup ignored", {res_valid, 2'b00}, 3'b000);

    // R4: write after frame accepted, map frame sees it
    wr(10, 10, 1, 0);
    open_frame(2'd2, 1'b1);
    look(43, 41);
    check("R4 new tile coded", {res_valid, res_coded, res_qsel}, 3'b110);
    close_frame();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule